// File: doc/BRIEF.md
# Buffered-Compare PWM Timer Channel

This block is one 16-bit up-counting timer channel that produces a single PWM waveform from two compare registers, A and B. The output goes high when the counter equals compare A and low when it equals compare B. The counter can also be cleared by one of those matches, which sets the PWM period.

Software changes the duty cycle without glitches by writing a buffer register. The channel copies the buffer into compare A at a chosen moment. A mode bit picks that moment:
- the compare-A match, or
- any counter-clear event: a wrap from 0xFFFF to 0x0000, a hardware clear, or software writing zero to the running counter.

Registers are loaded through a simple write port. A run input starts and stops counting. The counter, compare A and the mode bit are brought out for observation.

Top module: `pwm_buf_timer`

## Requirements
- R1: After reset the counter, compare A, compare B, buffer, clear select and mode are all 0, and the output pin is 0.
- R2: While `run` is 1 and no counter write occurs, the counter increments by one each cycle and wraps from 0xFFFF to 0x0000. While `run` is 0 and no counter write occurs, it holds.
- R3: Clear select (address 4, bits 2:0) works as follows: 001 clears the counter to 0 on a compare-A match, 010 clears it on a compare-B match, and every other code never clears it. A match is evaluated on the counter value before the increment, and only while running.
- R4: While running, a compare-A match drives the pin to 1 on the next cycle and a compare-B match drives it to 0. If both match at once, B wins. While stopped, the pin holds its level.
- R5: With mode bit 0, a compare-A match copies the buffer into compare A, and the new value is visible the next cycle.
- R6: With mode bit 1, the copy happens instead on a counter-clear event while running. The events are a wrap from 0xFFFF, a hardware clear from R3, and a bus write of 0x0000 to the counter.
- R7: The mode bit (address 5, bit 0) is written only while `run` is 0. A write while running leaves it unchanged.
- R8: Register addresses are 0 counter, 1 compare A, 2 compare B, 3 buffer. A write to compare A or to the buffer takes effect on the next cycle, and a compare-A write overrides a transfer in the same cycle.
- R9: A counter write overrides both increment and hardware clear, whether running or stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | 1 = count, 0 = stop |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..5) |
| wr_data | input | 16 | Write data |
| pwm_o | output | 1 | PWM waveform |
| cnt_o | output | 16 | Current counter value |
| cmp_a_o | output | 16 | Active compare A value |
| mode_o | output | 1 | Transfer mode bit (1 = on clear) |

## Verification
The assertions assume `run` and the write port are stable and defined at each rising edge, and that addresses 6 and 7 are never used as meaningful registers. The random stimulus drives inputs only at the falling edge and draws addresses from 0 to 5. It keeps compare values and counter writes in a small window, with occasional writes just below 0xFFFF, so that matches, hardware clears and wraps all occur often. The directed cases exercise each transfer event in turn and the locked mode bit.

// File: rtl/pwm_buf_timer.sv
module pwm_buf_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         pwm_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmp_a_o,
  output logic         mode_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt, cmp_a, cmp_b, buf_c;
  logic [2:0]   clr_sel;
  logic         mode, pwm;

  wire wr_cnt  = wr_en && wr_addr == 3'd0;
  wire wr_a    = wr_en && wr_addr == 3'd1;
  wire wr_b    = wr_en && wr_addr == 3'd2;
  wire wr_buf  = wr_en && wr_addr == 3'd3;
  wire wr_sel  = wr_en && wr_addr == 3'd4;
  wire wr_mode = wr_en && wr_addr == 3'd5;

  wire match_a  = run && cnt == cmp_a;
  wire match_b  = run && cnt == cmp_b;
  wire hw_clr   = (clr_sel == 3'b001 && match_a) || (clr_sel == 3'b010 && match_b);
  wire wrap     = run && cnt == MAXV;
  wire sw_zero  = run && wr_cnt && wr_data == '0;
  wire clr_evt  = hw_clr || wrap || sw_zero;
  wire xfer     = mode ? clr_evt : match_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      cmp_a   <= '0;
      cmp_b   <= '0;
      buf_c   <= '0;
      clr_sel <= '0;
      mode    <= 1'b0;
      pwm     <= 1'b0;
    end else begin
      if (wr_cnt)      cnt <= wr_data;
      else if (hw_clr) cnt <= '0;
      else if (run)    cnt <= cnt + 1'b1;

      if (wr_a)      cmp_a <= wr_data;
      else if (xfer) cmp_a <= buf_c;

      if (wr_b)   cmp_b   <= wr_data;
      if (wr_buf) buf_c   <= wr_data;
      if (wr_sel) clr_sel <= wr_data[2:0];
      if (wr_mode && !run) mode <= wr_data[0];

      if (match_b)      pwm <= 1'b0;
      else if (match_a) pwm <= 1'b1;
    end
  end

  assign pwm_o   = pwm;
  assign cnt_o   = cnt;
  assign cmp_a_o = cmp_a;
  assign mode_o  = mode;

  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_cnt |=> cnt == $past(cnt));
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && !wr_cnt && cnt == MAXV |=> cnt == '0);
  p_clear_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run && clr_sel == 3'b010 && cnt == cmp_b && !wr_cnt |=> cnt == '0);
  p_pwm_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run && cnt == cmp_a && cnt != cmp_b |=> pwm_o);
  p_pwm_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run && cnt == cmp_b |=> !pwm_o);
  p_pwm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pwm_o == $past(pwm_o));
  p_xfer_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run && !mode && cnt == cmp_a && !wr_a |=> cmp_a_o == $past(buf_c));
  p_xfer_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run && mode && cnt == MAXV && !wr_a |=> cmp_a_o == $past(buf_c));
  p_mode_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> mode_o == $past(mode_o));
  p_cnt_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(wr_data));
endmodule

// File: tb/test_pwm_buf_timer.sv
module test_pwm_buf_timer;
  logic clk = 0, rst_n = 0, run = 0, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic pwm_o, mode_o;
  logic [15:0] cnt_o, cmp_a_o;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_cnt, m_a, m_b, m_c;
  logic [2:0] m_sel;
  logic m_mode, m_pwm;

  always #4 clk = ~clk;

  pwm_buf_timer i_pwm_buf_timer (.clk, .rst_n, .run, .wr_en, .wr_addr, .wr_data,
    .pwm_o, .cnt_o, .cmp_a_o, .mode_o);

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic hw_clear(logic [2:0] s, logic ma, logic mb);
    return (s == 3'b001 && ma) || (s == 3'b010 && mb);
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_a = 0; m_b = 0; m_c = 0; m_sel = 0; m_mode = 0; m_pwm = 0;
  endtask

  task automatic model_step(bit r, bit w, logic [2:0] a, logic [15:0] d);
    logic ma, mb, hw, ev, xf;
    ma = r && m_cnt == m_a;
    mb = r && m_cnt == m_b;
    hw = hw_clear(m_sel, ma, mb);
    ev = hw || (r && m_cnt == 16'hFFFF) || (r && w && a == 0 && d == 0);
    xf = m_mode ? ev : ma;
    if (mb) m_pwm = 0; else if (ma) m_pwm = 1;
    if (w && a == 1) m_a = d; else if (xf) m_a = m_c;
    if (w && a == 0) m_cnt = d; else if (hw) m_cnt = 0; else if (r) m_cnt = m_cnt + 1;
    if (w && a == 2) m_b = d;
    if (w && a == 3) m_c = d;
    if (w && a == 4) m_sel = d[2:0];
    if (w && a == 5 && !r) m_mode = d[0];
  endtask

  task automatic step(bit r, bit w, logic [2:0] a, logic [15:0] d);
    run = r; wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_step(r, w, a, d);
    @(negedge clk);
    chk("R2 counter", cnt_o, m_cnt);
    chk("R5 compare A", cmp_a_o, m_a);
    chk("R4 pin", {15'd0, pwm_o}, {15'd0, m_pwm});
    chk("R7 mode", {15'd0, mode_o}, {15'd0, m_mode});
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd11));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 counter reset", cnt_o, 0);
    chk("R1 pin reset", {15'd0, pwm_o}, 0);
    chk("R1 mode reset", {15'd0, mode_o}, 0);
    chk("R1 compare reset", cmp_a_o, 0);

    step(0, 1, 5, 1);
    chk("R7 mode written stopped", {15'd0, mode_o}, 1);
    step(1, 1, 5, 0);
    chk("R7 mode write ignored running", {15'd0, mode_o}, 1);

    step(0, 1, 2, 16'h0100);
    step(0, 1, 1, 16'h0005);
    step(0, 1, 3, 16'h1234);
    step(0, 1, 0, 16'hFFFE);
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R2 wrap", cnt_o, 0);
    chk("R6 transfer on wrap", cmp_a_o, 16'h1234);

    step(1, 1, 3, 16'h0042);
    step(1, 1, 0, 16'h0000);
    chk("R6 transfer on zero write", cmp_a_o, 16'h0042);

    step(0, 1, 4, 2);
    step(0, 1, 2, 10);
    step(0, 1, 3, 16'h0077);
    step(0, 1, 0, 8);
    step(0, 0, 0, 0);
    chk("R2 hold stopped", cnt_o, 8);
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R6 no transfer before clear", cmp_a_o, 16'h0042);
    step(1, 0, 0, 0);
    chk("R3 clear on B", cnt_o, 0);
    chk("R6 transfer on hardware clear", cmp_a_o, 16'h0077);
    chk("R4 low after B", {15'd0, pwm_o}, 0);

    step(0, 1, 5, 0);
    step(0, 1, 4, 0);
    step(0, 1, 2, 16'h0300);
    step(0, 1, 1, 20);
    step(0, 1, 3, 30);
    step(0, 1, 0, 19);
    step(1, 0, 0, 0);
    chk("R5 no transfer before match", cmp_a_o, 20);
    step(1, 0, 0, 0);
    chk("R5 transfer on A match", cmp_a_o, 30);
    chk("R4 high after A", {15'd0, pwm_o}, 1);
    step(0, 0, 0, 0);
    chk("R4 hold stopped", {15'd0, pwm_o}, 1);

    step(1, 1, 1, 16'h0BEE);
    chk("R8 direct compare write", cmp_a_o, 16'h0BEE);
    step(1, 1, 0, 16'h0500);
    chk("R9 counter write running", cnt_o, 16'h0500);

    for (int i = 0; i < 4000; i++) begin
      bit r, w;
      logic [2:0] a;
      logic [15:0] d;
      r = ($urandom % 16) != 0;
      w = ($urandom % 6) == 0;
      a = 3'($urandom % 6);
      case (a)
        3'd0: d = ($urandom % 4 == 0) ? 16'd0 :
                  ($urandom % 3 == 0) ? 16'hFFF0 + 16'($urandom % 16) : 16'($urandom % 64);
        3'd4: d = 16'($urandom % 4);
        3'd5: d = 16'($urandom % 2);
        default: d = 16'($urandom % 64);
      endcase
      step(r, w, a, d);
    end

    done = 1;
    finish_run();
  end
endmodule